// File: doc/BRIEF.md
# Variable Character Height Line Mapper

This block decides, for every scan line of a text row, which line of an 18-line font the glyph fetch should read. It lets one fixed font serve several vertical scan rates. A 6-bit height code stretches the glyph. The glyph has one top line, sixteen middle lines and one bottom line. The top and bottom lines are repeated in coarse steps. The middle lines are spread over exactly as many scan lines as the height code gives. A rate-multiplier pattern chooses which middle lines get one extra repeat.

After the glyph, a programmable number of blank spacing lines is added. These keep the height of a whole menu constant when the code changes. A per-row double-height flag shows every font scan line twice, so one stored row fills two screen rows. The line timing logic drives two signals: a strobe for each new scan line and a pulse at the start of a row. The block returns the font line index, a flag that blanks the pixels on spacing lines, and an end-of-row flag. The row counter uses that flag to step to the next row.

Top module: `vch_line_mapper`

## Requirements
- R1: After reset, and after any `rowStart`, the current scan line is font line 0, `spaceLine` is low and `rowEnd` is low.
- R2: Let k = `heightCode[5:4]`, which takes the values 1, 2 or 3 for codes 16 to 63. The top font line (index 0) occupies the first k font scan lines of a row. The bottom font line (index 17) occupies the last k font scan lines.
- R3: Middle font lines 1 to 16 appear in ascending order. Together they occupy exactly `heightCode` font scan lines, and each one occupies k or k+1 of them.
- R4: Let m be a middle line's position, from 0 to 15, so its index is m+1. That line gets the extra (k+1)-th repeat exactly when the 4-bit bit-reversal of m is less than `heightCode[3:0]`.
- R5: The font part of a single-height row lasts `heightCode` + 2k scan lines.
- R6: After the font part come exactly `rowSpace` scan lines. On these `spaceLine` is 1 and `fontLine` is 0. When `rowSpace` is 0 there are none.
- R7: When `dblHeight` is 1, each font scan line is held for two `lineAdv` strobes. Spacing lines are not doubled.
- R8: `rowEnd` is high only on the last scan line of the row, counting spacing lines, and on no other line.
- R9: A `lineAdv` during the `rowEnd` line starts the next row at font line 0.
- R10: `rowStart` returns the mapper to the first scan line from any point in a row, and it wins over a simultaneous `lineAdv`.
- R11: While `lineAdv` and `rowStart` are both low, `fontLine` and `spaceLine` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| heightCode | input | 6 | Character height code, valid from 16 to 63 |
| rowSpace | input | 5 | Number of blank lines added after each row |
| dblHeight | input | 1 | Current row is double height |
| lineAdv | input | 1 | One-cycle strobe: move to the next scan line |
| rowStart | input | 1 | One-cycle strobe: restart at the first scan line of a row |
| fontLine | output | 5 | Font line index, 0 to 17, for the current scan line |
| spaceLine | output | 1 | Current scan line is a blank spacing line |
| rowEnd | output | 1 | Current scan line is the last of the row |

## Verification
The assertions check properties that hold on every cycle. The phase order runs top, middle, bottom, spacing. The middle index only steps by one or returns to zero. The state holds without strobes. A restart lands on the top phase. A strobe at row end wraps to line 0. The double-height half toggle rises only on a strobe in a double row. The actual line-by-line mapping can only be shown by the bench's directed rows. These rows cover the split between top, middle and bottom repeats, the bit-reversed placement of extra middle repeats, the spacing count, doubling and the exact row length. The bench runs them for several height codes, spacing values and the double flag, and compares each scan line to a model built from the requirements.

// File: rtl/vch_pkg.sv
package vch_pkg;

  typedef enum logic [1:0] {
    PH_TOP = 2'd0,
    PH_MID = 2'd1,
    PH_BOT = 2'd2,
    PH_GAP = 2'd3
  } phase_t;

  typedef struct packed {
    logic incCnt;
    logic clrCnt;
    logic incMid;
    logic clrMid;
    logic flipHalf;
    logic clrHalf;
  } strobes_t;

endpackage

// File: rtl/vch_extra_sel.sv
module vch_extra_sel #(
  parameter int MID_BITS = 4
) (
  input  logic [MID_BITS-1:0] midIdx,
  input  logic [MID_BITS-1:0] fracCode,
  output logic                extraRep
);
  logic [MID_BITS-1:0] revIdx;

  for (genvar b = 0; b < MID_BITS; b++) begin : g_rev
    assign revIdx[b] = midIdx[MID_BITS-1-b];
  end

  // Lines whose reversed position is below the fraction get one more repeat.
  assign extraRep = (revIdx < fracCode);
endmodule

// File: rtl/vch_datapath.sv
module vch_datapath
  import vch_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int SPACE_W  = 5,
  parameter int MID_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  phase_t              phase,
  input  strobes_t            strobes,
  input  logic [CODE_W-1:0]   heightCode,
  input  logic [SPACE_W-1:0]  rowSpace,
  output logic                cntLast,
  output logic                midLast,
  output logic                half,
  output logic [MID_BITS-1:0] midIdx
);
  localparam int KW    = CODE_W - MID_BITS;
  localparam int CNT_W = (SPACE_W > KW + 1) ? SPACE_W : KW + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] groupLen;
  logic [KW-1:0]    coarse;
  logic [KW-1:0]    coarseEff;
  logic             extraRep;

  assign coarse    = heightCode[CODE_W-1:MID_BITS];
  assign coarseEff = (coarse == '0) ? KW'(1) : coarse;

  vch_extra_sel #(.MID_BITS(MID_BITS)) u_extra (
    .midIdx  (midIdx),
    .fracCode(heightCode[MID_BITS-1:0]),
    .extraRep(extraRep)
  );

  always_comb begin
    unique case (phase)
      PH_TOP:  groupLen = CNT_W'(coarseEff);
      PH_MID:  groupLen = CNT_W'(coarseEff) + CNT_W'(extraRep);
      PH_BOT:  groupLen = CNT_W'(coarseEff);
      default: groupLen = CNT_W'(rowSpace);
    endcase
  end

  assign cntLast = (cnt == groupLen - CNT_W'(1));
  assign midLast = (midIdx == {MID_BITS{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      midIdx <= '0;
      half   <= 1'b0;
    end else begin
      if (strobes.clrCnt)      cnt <= '0;
      else if (strobes.incCnt) cnt <= cnt + CNT_W'(1);

      if (strobes.clrMid)      midIdx <= '0;
      else if (strobes.incMid) midIdx <= midIdx + MID_BITS'(1);

      if (strobes.clrHalf)       half <= 1'b0;
      else if (strobes.flipHalf) half <= ~half;
    end
  end

  // R3: the middle index only steps up by one or returns to zero.
  p_mid_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (midIdx != $past(midIdx) && midIdx != '0) |-> midIdx == $past(midIdx) + MID_BITS'(1));

endmodule

// File: rtl/vch_control.sv
module vch_control
  import vch_pkg::*;
#(
  parameter int SPACE_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineAdv,
  input  logic               rowStart,
  input  logic               dblHeight,
  input  logic [SPACE_W-1:0] rowSpace,
  input  logic               cntLast,
  input  logic               midLast,
  input  logic               half,
  output phase_t             phase,
  output strobes_t           strobes,
  output logic               rowEnd
);
  phase_t phaseNext;
  logic   fontPhase;
  logic   secondHalf;
  logic   lastGroup;

  assign fontPhase  = (phase != PH_GAP);
  assign secondHalf = !fontPhase || !dblHeight || half;
  assign lastGroup  = (phase == PH_GAP) || (phase == PH_BOT && rowSpace == '0);
  assign rowEnd     = lastGroup && cntLast && secondHalf;

  always_comb begin
    strobes   = '0;
    phaseNext = phase;
    if (rowStart) begin
      strobes.clrCnt  = 1'b1;
      strobes.clrMid  = 1'b1;
      strobes.clrHalf = 1'b1;
      phaseNext       = PH_TOP;
    end else if (lineAdv) begin
      if (!secondHalf) begin
        strobes.flipHalf = 1'b1;
      end else begin
        strobes.clrHalf = 1'b1;
        if (!cntLast) begin
          strobes.incCnt = 1'b1;
        end else begin
          strobes.clrCnt = 1'b1;
          unique case (phase)
            PH_TOP: begin
              phaseNext      = PH_MID;
              strobes.clrMid = 1'b1;
            end
            PH_MID: begin
              if (midLast) phaseNext = PH_BOT;
              else         strobes.incMid = 1'b1;
            end
            PH_BOT: begin
              phaseNext      = (rowSpace == '0) ? PH_TOP : PH_GAP;
              strobes.clrMid = 1'b1;
            end
            default: begin
              phaseNext      = PH_TOP;
              strobes.clrMid = 1'b1;
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_TOP;
    else       phase <= phaseNext;
  end

  // R10: a restart always lands on the top phase.
  p_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    rowStart |=> phase == PH_TOP);

  // R11: without strobes the phase holds.
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!lineAdv && !rowStart) |=> $stable(phase));

  // R5: the bottom phase is only entered from the middle phase.
  p_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_BOT && $past(phase) != PH_BOT) |-> $past(phase) == PH_MID);

  // R6: spacing lines only follow the bottom font line.
  p_gap_after_bot_r6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_GAP && $past(phase) != PH_GAP) |-> $past(phase) == PH_BOT);

endmodule

// File: rtl/vch_line_mapper.sv
module vch_line_mapper
  import vch_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int SPACE_W  = 5,
  parameter int MID_BITS = 4,
  parameter int LINE_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CODE_W-1:0]  heightCode,
  input  logic [SPACE_W-1:0] rowSpace,
  input  logic               dblHeight,
  input  logic               lineAdv,
  input  logic               rowStart,
  output logic [LINE_W-1:0]  fontLine,
  output logic               spaceLine,
  output logic               rowEnd
);
  localparam int FONT_LINES = (1 << MID_BITS) + 2;

  phase_t              phase;
  strobes_t            strobes;
  logic                cntLast;
  logic                midLast;
  logic                half;
  logic [MID_BITS-1:0] midIdx;

  vch_control #(.SPACE_W(SPACE_W)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .lineAdv  (lineAdv),
    .rowStart (rowStart),
    .dblHeight(dblHeight),
    .rowSpace (rowSpace),
    .cntLast  (cntLast),
    .midLast  (midLast),
    .half     (half),
    .phase    (phase),
    .strobes  (strobes),
    .rowEnd   (rowEnd)
  );

  vch_datapath #(
    .CODE_W  (CODE_W),
    .SPACE_W (SPACE_W),
    .MID_BITS(MID_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .phase     (phase),
    .strobes   (strobes),
    .heightCode(heightCode),
    .rowSpace  (rowSpace),
    .cntLast   (cntLast),
    .midLast   (midLast),
    .half      (half),
    .midIdx    (midIdx)
  );

  always_comb begin
    unique case (phase)
      PH_TOP:  fontLine = '0;
      PH_MID:  fontLine = LINE_W'(midIdx) + LINE_W'(1);
      PH_BOT:  fontLine = LINE_W'(FONT_LINES - 1);
      default: fontLine = '0;
    endcase
  end

  assign spaceLine = (phase == PH_GAP);

  // R9: a strobe on the last line wraps to font line 0.
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rowEnd && lineAdv && !rowStart) |=> (fontLine == '0 && !spaceLine));

  // R7: the repeat half only rises on a strobe in a double-height row.
  p_half_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(half) |-> ($past(lineAdv) && $past(dblHeight)));

endmodule

// File: tb/tb_vch_line_mapper.sv
module tb_vch_line_mapper;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] heightCode = 6'd16;
  logic [4:0] rowSpace = 5'd0;
  logic       dblHeight = 1'b0;
  logic       lineAdv = 1'b0;
  logic       rowStart = 1'b0;
  logic [4:0] fontLine;
  logic       spaceLine;
  logic       rowEnd;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vch_line_mapper dut (
    .clk(clk), .rstN(rstN), .heightCode(heightCode), .rowSpace(rowSpace),
    .dblHeight(dblHeight), .lineAdv(lineAdv), .rowStart(rowStart),
    .fontLine(fontLine), .spaceLine(spaceLine), .rowEnd(rowEnd)
  );

  function automatic int rev4(input int v);
    return ((v & 1) << 3) | ((v & 2) << 1) | ((v & 4) >> 1) | ((v & 8) >> 3);
  endfunction

  // Model from the requirements: line index, spacing flag, end flag.
  function automatic void model(input int code, input int sp, input int dbl, input int idx,
                                output int line, output bit spc, output bit endf);
    int k, e, d, f, p, acc, reps;
    k = code >> 4; e = code & 15; d = dbl ? 2 : 1;
    endf = (idx == (code + 2 * k) * d + sp - 1);
    spc = 1'b0; line = 0;
    if (idx >= (code + 2 * k) * d) begin
      spc = 1'b1;
    end else begin
      f = idx / d;
      if (f < k) line = 0;
      else if (f >= k + code) line = 17;
      else begin
        p = f - k; acc = 0;
        for (int m = 0; m < 16; m++) begin
          reps = k + ((rev4(m) < e) ? 1 : 0);
          if (p >= acc && p < acc + reps) line = m + 1;
          acc += reps;
        end
      end
    end
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic advance();
    lineAdv = 1'b1;
    @(negedge clk);
    lineAdv = 1'b0;
  endtask

  task automatic restart();
    rowStart = 1'b1;
    @(negedge clk);
    rowStart = 1'b0;
  endtask

  // Walks one whole row and compares every scan line.
  task automatic runRow(input int code, input int sp, input int dbl);
    int total, line, fontCnt, midCnt, k;
    bit spc, endf;
    string req;
    heightCode = 6'(code); rowSpace = 5'(sp); dblHeight = dbl[0];
    restart();
    k = code >> 4;
    total = (code + 2 * k) * (dbl ? 2 : 1) + sp;
    fontCnt = 0; midCnt = 0;
    for (int i = 0; i < total; i++) begin
      model(code, sp, dbl, i, line, spc, endf);
      if (dbl != 0 && !spc) req = "R7";
      else if (spc) req = "R6";
      else if (line == 0 || line == 17) req = "R2";
      else req = "R4";
      check(fontLine == 5'(line) && spaceLine == spc, req, $sformatf("line %0d of code %0d", i, code),
            {27'd0, spaceLine, fontLine}, (int'(spc) << 5) | line);
      check(rowEnd == endf, "R8", $sformatf("rowEnd at line %0d of code %0d", i, code), rowEnd, endf);
      if (!spaceLine) fontCnt++;
      if (!spaceLine && fontLine >= 1 && fontLine <= 16) midCnt++;
      advance();
    end
    check(midCnt == code * (dbl ? 2 : 1), "R3", "middle scan lines", midCnt, code * (dbl ? 2 : 1));
    check(fontCnt == (code + 2 * k) * (dbl ? 2 : 1), "R5", "font scan lines", fontCnt,
          (code + 2 * k) * (dbl ? 2 : 1));
    check(fontLine == 0 && !spaceLine && !rowEnd, "R9", "wrap to next row", fontLine, 0);
  endtask

  task automatic tReset();
    check(fontLine == 0 && !spaceLine && !rowEnd, "R1", "state after reset", fontLine, 0);
  endtask

  task automatic tRestart();
    heightCode = 6'd34; rowSpace = 5'd3; dblHeight = 1'b0;
    restart();
    for (int i = 0; i < 20; i++) advance();
    rowStart = 1'b1; lineAdv = 1'b1;
    @(negedge clk);
    rowStart = 1'b0; lineAdv = 1'b0;
    check(fontLine == 0 && !spaceLine && !rowEnd, "R10", "restart wins over advance", fontLine, 0);
    check(fontLine == 0 && !rowEnd, "R1", "first line after rowStart", fontLine, 0);
  endtask

  task automatic tHold();
    logic [4:0] held;
    heightCode = 6'd40; rowSpace = 5'd2; dblHeight = 1'b0;
    restart();
    for (int i = 0; i < 9; i++) advance();
    held = fontLine;
    repeat (6) @(negedge clk);
    check(fontLine == held && !spaceLine, "R11", "hold without strobe", fontLine, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    runRow(25, 0, 0);
    runRow(34, 3, 0);
    runRow(16, 0, 0);
    runRow(63, 31, 0);
    runRow(48, 2, 1);
    runRow(29, 1, 1);
    tRestart();
    tHold();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(100000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule